// File: doc/BRIEF.md
# Two-word-per-cycle dictionary cache line compressor

This block turns one 64-byte cache line into a lossless variable-length bit stream. The line arrives as sixteen 32-bit words, two per clock, over eight accepted pairs. Each word is encoded in one of two ways. A word that is all zero, or zero in every byte except the least significant one, gets a short fixed code. Any other word is compared in parallel against a small first-in first-out dictionary. The result is a code made of a prefix, an optional entry index and the bytes that did not match.

Every word that takes no fixed code is written into the dictionary, so later words can refer back to it. The dictionary is emptied at the start of each line. The second word of a pair is searched against the dictionary as it will stand once the first word has been inserted. This lets two words go through per cycle without losing any compression. The codes are packed most significant bit first into a 512-bit result, together with the total code length in bits. A one-cycle flag marks the end of the line.

Top module: `line_packer`

## Requirements
- R1: A word equal to 0x00000000 is encoded as the 2-bit code 00.
- R2: A nonzero word whose upper three bytes are zero is encoded as 1101 followed by its low byte, 12 bits in total.
- R3: A non-fixed word equal to a valid dictionary entry is encoded as 10 followed by the 4-bit slot index, 6 bits in total. Slots are filled in order 0, 1, 2 and so on from the start of the line.
- R4: Otherwise, the encoding depends on how many of the word's upper bytes agree with an entry. With the upper three bytes agreeing it is 1110, index, low byte (16 bits). With only the upper two bytes agreeing it is 1100, index, low 16 bits (24 bits). With no such entry it is 01 followed by the full word (34 bits). The entry with the most agreeing bytes wins, and on a tie the lowest slot wins.
- R5: Only words that take neither fixed code (R1, R2) are inserted into the dictionary. Fixed-code words do not use up a slot.
- R6: The second word of a pair (word_b_i) is searched as if the first word (word_a_i) had already been inserted. This gives the same result as encoding the words one at a time.
- R7: Codes are packed first-word-first and most significant bit first from bits_o[511] downward. len_o is the exact sum of the code lengths, up to 544. Code bits that fall past bit position 512 are dropped.
- R8: done_o is high for exactly one cycle: the cycle after the edge that accepts the eighth pair. bits_o and len_o hold their values after that.
- R9: start_i empties the dictionary and clears len_o, bits_o and done_o. Any pair presented in the same cycle as start_i is ignored.
- R10: Pairs offered after the eighth pair of a line are ignored until the next start_i.
- R11: After reset, done_o, len_o and bits_o are zero and a line may begin without a start_i.
- R12: Cycles with in_valid_i low change nothing, so pairs may arrive with gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new line; clears dictionary and result |
| in_valid_i | input | 1 | A word pair is offered this cycle |
| word_a_i | input | 32 | Earlier word of the pair |
| word_b_i | input | 32 | Later word of the pair |
| done_o | output | 1 | One-cycle pulse after the eighth pair |
| bits_o | output | 512 | Packed code stream, first code at the MSB |
| len_o | output | 10 | Total code length in bits |

## Verification
The bench compares each line with a serial word-by-word model. If the second word were searched against the stale dictionary, a repeated word in the same pair would cost 34 bits instead of 6 and the totals would not match. Crafted lines cover the other corner cases:
- Fixed words placed before dictionary words catch a design that lets those words occupy a slot; its indices would shift by one.
- Byte-partial matches between entries check the tie-breaking and the choice of most matching bytes.
- A line of words that all differ in their upper half overflows 512 bits. It exposes a length counter that saturates or a packer that wraps around.
- Gaps, surplus pairs and a pair offered with start_i check that none of these disturb the result.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int WORD_W = 32;
    localparam int CODE_W = 34;   // longest code: 2-bit prefix + full word
    localparam int CLEN_W = 6;    // width of one code length

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_HALF = 2'd1,
        LVL_TRI  = 2'd2,
        LVL_FULL = 2'd3
    } match_lvl_e;
endpackage

// File: rtl/lp_match.sv
module lp_match #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [lp_pkg::WORD_W-1:0]              word_i,
    input  logic [ENTRIES-1:0][lp_pkg::WORD_W-1:0] cand_i,
    input  logic [ENTRIES-1:0]                     cand_vld_i,
    output logic [lp_pkg::CODE_W-1:0]              code_o,
    output logic [lp_pkg::CLEN_W-1:0]              len_o,
    output logic                                   static_o
);
    import lp_pkg::*;

    match_lvl_e       best;
    match_lvl_e       lvl;
    logic [IDX_W-1:0] best_idx;

    // Parallel search over all entries; strict compare keeps the lowest slot on ties.
    always_comb begin
        best     = LVL_NONE;
        best_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lvl = LVL_NONE;
            if (cand_vld_i[i] && cand_i[i][31:16] == word_i[31:16]) begin
                if (cand_i[i][15:0] == word_i[15:0])     lvl = LVL_FULL;
                else if (cand_i[i][15:8] == word_i[15:8]) lvl = LVL_TRI;
                else                                      lvl = LVL_HALF;
            end
            if (lvl > best) begin
                best     = lvl;
                best_idx = IDX_W'(i);
            end
        end
    end

    // Code selection; every code is left-justified in CODE_W bits.
    always_comb begin
        static_o = 1'b0;
        if (word_i == '0) begin
            static_o = 1'b1;
            code_o   = {2'b00, 32'd0};
            len_o    = CLEN_W'(2);
        end else if (word_i[31:8] == '0) begin
            static_o = 1'b1;
            code_o   = {4'b1101, word_i[7:0], 22'd0};
            len_o    = CLEN_W'(12);
        end else begin
            unique case (best)
                LVL_FULL: begin
                    code_o = {2'b10, best_idx, {(CODE_W-2-IDX_W){1'b0}}};
                    len_o  = CLEN_W'(2 + IDX_W);
                end
                LVL_TRI: begin
                    code_o = {4'b1110, best_idx, word_i[7:0], {(CODE_W-12-IDX_W){1'b0}}};
                    len_o  = CLEN_W'(12 + IDX_W);
                end
                LVL_HALF: begin
                    code_o = {4'b1100, best_idx, word_i[15:0], {(CODE_W-20-IDX_W){1'b0}}};
                    len_o  = CLEN_W'(20 + IDX_W);
                end
                default: begin
                    code_o = {2'b01, word_i};
                    len_o  = CLEN_W'(CODE_W);
                end
            endcase
        end
    end
endmodule

// File: rtl/lp_bit_append.sv
module lp_bit_append #(
    parameter int OUT_W = 512,
    parameter int POS_W = 10
) (
    input  logic [OUT_W-1:0]          acc_i,
    input  logic [POS_W-1:0]          pos_i,
    input  logic [lp_pkg::CODE_W-1:0] code_i,
    output logic [OUT_W-1:0]          acc_o
);
    localparam int WIDE_W = OUT_W + lp_pkg::CODE_W;

    logic [WIDE_W-1:0] wide;

    // Place the left-justified code at bit offset pos_i from the MSB; overflow falls off.
    always_comb begin
        wide  = {code_i, {OUT_W{1'b0}}} >> pos_i;
        acc_o = acc_i | wide[WIDE_W-1:lp_pkg::CODE_W];
    end
endmodule

// File: rtl/line_packer.sv
module line_packer #(
    parameter int LINE_WORDS   = 16,
    parameter int DICT_ENTRIES = 16,
    parameter int OUT_W        = 512
) (
    input  logic                                                 clk,
    input  logic                                                 rst_n,
    input  logic                                                 start_i,
    input  logic                                                 in_valid_i,
    input  logic [31:0]                                          word_a_i,
    input  logic [31:0]                                          word_b_i,
    output logic                                                 done_o,
    output logic [OUT_W-1:0]                                     bits_o,
    output logic [$clog2(LINE_WORDS*lp_pkg::CODE_W+1)-1:0]       len_o
);
    import lp_pkg::*;

    localparam int IDX_W = $clog2(DICT_ENTRIES);
    localparam int PAIRS = LINE_WORDS / 2;
    localparam int CNT_W = $clog2(PAIRS + 1);
    localparam int LEN_W = $clog2(LINE_WORDS * CODE_W + 1);

    typedef struct packed {
        logic [DICT_ENTRIES-1:0][WORD_W-1:0] dict;
        logic [DICT_ENTRIES-1:0]             vld;
        logic [IDX_W-1:0]                    wptr;
        logic [CNT_W-1:0]                    pairs;
        logic [LEN_W-1:0]                    pos;
        logic [OUT_W-1:0]                    acc;
        logic                                done;
    } state_t;

    state_t s_q, s_d;

    logic [CODE_W-1:0]                   code_a, code_b;
    logic [CLEN_W-1:0]                   clen_a, clen_b;
    logic                                stat_a, stat_b;
    logic [DICT_ENTRIES-1:0][WORD_W-1:0] cand_b;
    logic [DICT_ENTRIES-1:0]             cand_vld_b;
    logic [OUT_W-1:0]                    acc_mid, acc_end;
    logic [LEN_W-1:0]                    pos_mid, pos_end;
    logic                                accept;

    lp_match #(.ENTRIES(DICT_ENTRIES), .IDX_W(IDX_W)) u_match_a (
        .word_i(word_a_i), .cand_i(s_q.dict), .cand_vld_i(s_q.vld),
        .code_o(code_a), .len_o(clen_a), .static_o(stat_a)
    );

    // Second word sees the dictionary after the first word's insertion:
    // the slot about to be written holds word_a instead of its old contents.
    always_comb begin
        cand_b     = s_q.dict;
        cand_vld_b = s_q.vld;
        if (!stat_a) begin
            cand_b[s_q.wptr]     = word_a_i;
            cand_vld_b[s_q.wptr] = 1'b1;
        end
    end

    lp_match #(.ENTRIES(DICT_ENTRIES), .IDX_W(IDX_W)) u_match_b (
        .word_i(word_b_i), .cand_i(cand_b), .cand_vld_i(cand_vld_b),
        .code_o(code_b), .len_o(clen_b), .static_o(stat_b)
    );

    assign pos_mid = s_q.pos + LEN_W'(clen_a);
    assign pos_end = pos_mid + LEN_W'(clen_b);

    lp_bit_append #(.OUT_W(OUT_W), .POS_W(LEN_W)) u_app_a (
        .acc_i(s_q.acc), .pos_i(s_q.pos), .code_i(code_a), .acc_o(acc_mid)
    );
    lp_bit_append #(.OUT_W(OUT_W), .POS_W(LEN_W)) u_app_b (
        .acc_i(acc_mid), .pos_i(pos_mid), .code_i(code_b), .acc_o(acc_end)
    );

    assign accept = in_valid_i && !start_i && (s_q.pairs != CNT_W'(PAIRS));

    always_comb begin
        logic [IDX_W-1:0] wp;
        s_d      = s_q;
        s_d.done = 1'b0;
        wp       = s_q.wptr;
        if (start_i) begin
            s_d.vld   = '0;
            s_d.wptr  = '0;
            s_d.pairs = '0;
            s_d.pos   = '0;
            s_d.acc   = '0;
        end else if (accept) begin
            s_d.acc   = acc_end;
            s_d.pos   = pos_end;
            s_d.pairs = s_q.pairs + CNT_W'(1);
            s_d.done  = (s_q.pairs == CNT_W'(PAIRS - 1));
            if (!stat_a) begin
                s_d.dict[wp] = word_a_i;
                s_d.vld[wp]  = 1'b1;
                wp           = wp + IDX_W'(1);
            end
            if (!stat_b) begin
                s_d.dict[wp] = word_b_i;
                s_d.vld[wp]  = 1'b1;
                wp           = wp + IDX_W'(1);
            end
            s_d.wptr = wp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
    assign bits_o = s_q.acc;
    assign len_o  = s_q.pos;
endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
    parameter int OUT_W = 512,
    parameter int LEN_W = 10,
    parameter int PAIRS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_valid_i,
    input logic             done_o,
    input logic [OUT_W-1:0] bits_o,
    input logic [LEN_W-1:0] len_o
);
    localparam int CNT_W = $clog2(PAIRS + 1);

    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                       seen_q <= '0;
        else if (start_i)                                 seen_q <= '0;
        else if (in_valid_i && seen_q != CNT_W'(PAIRS))   seen_q <= seen_q + CNT_W'(1);
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> seen_q == CNT_W'(PAIRS));

    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (len_o == '0 && bits_o == '0 && !done_o));

    assert_len_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !start_i && seen_q != CNT_W'(PAIRS)) |=>
        (32'(len_o) >= 32'($past(len_o)) + 4 && 32'(len_o) <= 32'($past(len_o)) + 68));

    assert_extra_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && seen_q == CNT_W'(PAIRS)) |=> ($stable(bits_o) && $stable(len_o)));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !in_valid_i) |=> ($stable(bits_o) && $stable(len_o)));
endmodule

bind line_packer lp_checker #(.OUT_W(OUT_W), .LEN_W(LEN_W), .PAIRS(PAIRS)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .done_o(done_o), .bits_o(bits_o), .len_o(len_o)
);

// File: tb/tb_line_packer.sv
`timescale 1ns/1ps
module tb_line_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [31:0]  word_a_i = '0;
    logic [31:0]  word_b_i = '0;
    logic         done_o;
    logic [511:0] bits_o;
    logic [9:0]   len_o;

    int checks = 0;
    int fails  = 0;

    line_packer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
        .word_a_i(word_a_i), .word_b_i(word_b_i),
        .done_o(done_o), .bits_o(bits_o), .len_o(len_o)
    );

    always #5 clk = ~clk;

    // Serial reference model
    logic [31:0]  m_dict [16];
    int           m_cnt;
    int           m_pos;
    logic [511:0] m_acc;
    logic [31:0]  rs = 32'h1badcafe;

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_cnt = 0; m_pos = 0; m_acc = '0;
    endtask

    task automatic model_word(input logic [31:0] w);
        logic [33:0] c;
        int          l;
        int          best;
        int          bi;
        best = 0; bi = 0;
        if (w == 0) begin
            c = 34'd0; l = 2;
        end else if (w[31:8] == 0) begin
            c = {22'd0, 4'hD, w[7:0]}; l = 12;
        end else begin
            for (int i = 0; i < m_cnt && i < 16; i++) begin
                int lv;
                lv = 0;
                if (m_dict[i][31:16] == w[31:16])
                    lv = (m_dict[i] == w) ? 4 : ((m_dict[i][15:8] == w[15:8]) ? 3 : 2);
                if (lv > best) begin best = lv; bi = i; end
            end
            case (best)
                4:       begin c = {28'd0, 2'b10, 4'(bi)};          l = 6;  end
                3:       begin c = {18'd0, 4'hE, 4'(bi), w[7:0]};   l = 16; end
                2:       begin c = {10'd0, 4'hC, 4'(bi), w[15:0]};  l = 24; end
                default: begin c = {2'b01, w};                      l = 34; end
            endcase
            m_dict[m_cnt % 16] = w;
            m_cnt++;
        end
        for (int k = 0; k < l; k++)
            if (m_pos + k < 512) m_acc[511 - (m_pos + k)] = c[l - 1 - k];
        m_pos += l;
    endtask

    task automatic run_line(input logic [31:0] ln [16], input bit gaps);
        model_clear();
        for (int i = 0; i < 16; i++) model_word(ln[i]);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk(len_o == 0 && bits_o == 0 && !done_o, "R9 start clears", 512'(len_o), 0);
        for (int p = 0; p < 8; p++) begin
            if (gaps) begin
                in_valid_i = 1'b0; word_a_i = 32'hffff_ffff; word_b_i = 32'h1234_5678;
                @(negedge clk);
            end
            in_valid_i = 1'b1; word_a_i = ln[2*p]; word_b_i = ln[2*p+1];
            @(negedge clk);
            if (p == 6) chk(!done_o, "R8 no done before last pair", 512'(done_o), 0);
        end
        in_valid_i = 1'b0;
        chk(done_o, "R8 done after eighth pair", 512'(done_o), 1);
        chk(32'(len_o) == m_pos, "R7 length", 512'(len_o), 512'(m_pos));
        chk(bits_o == m_acc, "R6/R7 stream", bits_o, m_acc);
        @(negedge clk);
        chk(!done_o, "R8 done single pulse", 512'(done_o), 0);
    endtask

    function automatic logic [31:0] rnd_word();
        logic [7:0] b3, b2, b1, b0;
        rs = rs * 32'd1103515245 + 32'd12345;
        case (rs[17:16]) 2'd0: b3 = 8'h00; 2'd1: b3 = 8'h11; default: b3 = 8'h22; endcase
        b2 = rs[19] ? 8'h33 : 8'h00;
        b1 = rs[21] ? 8'h44 : 8'h00;
        case (rs[24:23]) 2'd0: b0 = 8'h00; 2'd1: b0 = 8'h55; default: b0 = 8'h66; endcase
        return {b3, b2, b1, b0};
    endfunction

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] ln [16];
        logic [9:0]  hold_len;
        logic [511:0] hold_bits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done_o && len_o == 0 && bits_o == 0, "R11 reset state", 512'(len_o), 0);

        // R1: all-zero line
        for (int i = 0; i < 16; i++) ln[i] = 32'd0;
        run_line(ln, 1'b0);
        chk(len_o == 10'd32 && bits_o == 0, "R1 zero words", 512'(len_o), 512'd32);

        // R2: low-byte-only words
        for (int i = 0; i < 16; i++) ln[i] = 32'h0000_00AB;
        run_line(ln, 1'b0);
        chk(len_o == 10'd192, "R2 length", 512'(len_o), 512'd192);
        chk(bits_o[511:500] == 12'hDAB, "R2 first code", 512'(bits_o[511:500]), 512'hDAB);

        // R3/R6: one repeated word; the second of the first pair hits slot 0
        for (int i = 0; i < 16; i++) ln[i] = 32'hDEAD_BEEF;
        run_line(ln, 1'b0);
        chk(len_o == 10'd124, "R3 R6 length", 512'(len_o), 512'd124);
        chk(bits_o[511:472] == {2'b01, 32'hDEADBEEF, 6'b100000}, "R3 R6 codes",
            512'(bits_o[511:472]), 512'({2'b01, 32'hDEADBEEF, 6'b100000}));

        // R4: three-byte and two-byte partial matches with tie to slot 0
        for (int i = 0; i < 16; i++) ln[i] = 32'd0;
        ln[0] = 32'h1234_5678; ln[1] = 32'h1234_5699; ln[2] = 32'h1234_AAAA;
        run_line(ln, 1'b0);
        chk(len_o == 10'd100, "R4 length", 512'(len_o), 512'd100);
        chk(bits_o[511:438] == {2'b01, 32'h12345678, 4'hE, 4'd0, 8'h99, 4'hC, 4'd0, 16'hAAAA},
            "R4 codes", 512'(bits_o[511:438]),
            512'({2'b01, 32'h12345678, 4'hE, 4'd0, 8'h99, 4'hC, 4'd0, 16'hAAAA}));

        // R5: a fixed-code word does not take slot 0
        for (int i = 0; i < 16; i++) ln[i] = 32'd0;
        ln[0] = 32'h0000_00AB; ln[1] = 32'h5566_7788; ln[2] = 32'h5566_7788;
        run_line(ln, 1'b0);
        chk(len_o == 10'd78, "R5 length", 512'(len_o), 512'd78);
        chk(bits_o[511:460] == {4'hD, 8'hAB, 2'b01, 32'h55667788, 2'b10, 4'd0}, "R5 index",
            512'(bits_o[511:460]), 512'({4'hD, 8'hAB, 2'b01, 32'h55667788, 2'b10, 4'd0}));

        // R7: sixteen unmatched words overflow 512 bits
        for (int i = 0; i < 16; i++) ln[i] = {8'(i + 1), 8'h5A, 16'h1234};
        run_line(ln, 1'b0);
        chk(len_o == 10'd544, "R7 overflow length", 512'(len_o), 512'd544);

        // R12: gaps between pairs
        for (int i = 0; i < 16; i++) ln[i] = rnd_word();
        run_line(ln, 1'b1);

        // R10: surplus pairs after the line
        hold_len = len_o; hold_bits = bits_o;
        in_valid_i = 1'b1; word_a_i = 32'hCAFE_0001; word_b_i = 32'h0000_0000;
        repeat (2) @(negedge clk);
        in_valid_i = 1'b0;
        chk(len_o == hold_len && bits_o == hold_bits && !done_o, "R10 surplus ignored",
            512'(len_o), 512'(hold_len));

        // R9: a pair offered with start is dropped
        @(negedge clk);
        start_i = 1'b1; in_valid_i = 1'b1; word_a_i = 32'h7777_7777; word_b_i = 32'h0000_0001;
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0;
        chk(len_o == 0 && bits_o == 0, "R9 pair with start ignored", 512'(len_o), 0);

        // Sweep over a small byte alphabet: R4, R5, R6, R7
        for (int n = 0; n < 150; n++) begin
            for (int i = 0; i < 16; i++) ln[i] = rnd_word();
            run_line(ln, n[0]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule